// File: doc/BRIEF.md
# ADC Conversion Sequencer with Buffered Channel Select

This block is the digital sequencer for a 10-bit successive-approximation converter. Software writes a control register, a selection register (input channel plus voltage reference) and a flag-clear register through a small write port. A conversion can start in three ways: a start pulse, an automatic restart in free-running mode, or the processor halting into one of the two quiet sleep states. The block counts conversion time in ticks of an externally supplied ADC clock enable. It holds the chosen channel and reference steady towards the analog core while a conversion runs, and it captures the core's code when the conversion ends.

Software selections go to a pending register. They are copied to the active selection only while a change cannot hurt a conversion that is already under way. The analog core samples the active selection on the first ADC tick of each conversion. Because of this, in free-running mode one result after a channel change still carries the old channel. That result, and the first result after a reference change, are marked with a stale bit. A completion flag is set at each end of conversion. An interrupt line is the flag gated by its enable.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after its release: busy_o, irq_flag_o, irq_o, stale_o and result_o are all zero.
- R2: With the enable bit set (control register, address 0, bit 0) and the converter idle, a start_i pulse raises busy_o on the next clock. busy_o stays high for exactly 13 ADC ticks. At the last tick, result_o takes core_code_i and irq_flag_o sets. In single mode the converter then stays idle.
- R3: The first conversion after the enable bit goes from 0 to 1 lasts 25 ADC ticks instead of 13.
- R4: While the enable bit is clear, start_i has no effect: busy_o and irq_flag_o stay low.
- R5: The selection register (address 1: channel in bits 3:0, reference in bits 5:4) has these effects. A value written before a start is used by that conversion. A value written after the conversion's first ADC tick does not change it and is used by the next conversion.
- R6: In free-running mode (control bit 1 with enable set), a new conversion begins in the same cycle that one ends. A channel written while conversion N runs is not used by N. N's result carries the old channel with stale_o = 1. Conversion N+1 uses the new channel with stale_o = 0.
- R7: The first conversion after a change of the reference field reports stale_o = 1. The following conversion, with an unchanged reference, reports stale_o = 0.
- R8: Writing 1 to bit 0 of address 2 clears irq_flag_o. Writing 0 there leaves it set.
- R9: irq_o is high exactly when irq_flag_o is set and the interrupt enable (control bit 2) is set.
- R10: A rising edge of cpu_halt_i starts a conversion when all of these hold: sleep_kind_i is 0 (idle) or 1 (quiet); the block is enabled, idle and not free-running; and the interrupt enable is set. That conversion still completes and sets the flag if cpu_halt_i falls before the end. Kinds 2 and 3 start nothing and leave the enable unchanged.
- R11: Clearing the enable bit during a conversion drops busy_o within two clocks of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_tick_i | input | 1 | One-cycle ADC clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 selection, 2 flag clear |
| wr_data_i | input | 6 | Register write data |
| start_i | input | 1 | Software start pulse |
| cpu_halt_i | input | 1 | Processor halted in a sleep state |
| sleep_kind_i | input | 2 | Sleep state: 0 idle, 1 quiet, 2 deep, 3 standby |
| core_code_i | input | 10 | Conversion code from the analog core |
| core_sample_o | output | 1 | Pulse at which the core samples the selection |
| core_chan_o | output | 4 | Channel held for the running conversion |
| core_ref_o | output | 2 | Reference held for the running conversion |
| busy_o | output | 1 | Conversion in progress |
| irq_flag_o | output | 1 | Conversion-complete flag |
| irq_o | output | 1 | Interrupt request |
| result_o | output | 10 | Last conversion code |
| stale_o | output | 1 | Last result should be discarded |

## Verification
The hardest situation to reach is a free-running conversion whose selection has been rewritten after the automatic restart. The write must land between two completions. The result of that conversion must carry the old channel and the stale mark, and the result after it must carry the new channel. The stimulus waits for the completion flag, clears it, lets two ADC ticks of the restarted conversion pass, and only then writes the new channel. It then follows two more completions. The analog stub folds the channel and the reference into its code, so every result shows which selection the core actually sampled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CHAN_W = 4;
  localparam int REF_W  = 2;
  localparam int DATA_W = CHAN_W + REF_W;

  typedef struct packed {
    logic [REF_W-1:0]  refsel;
    logic [CHAN_W-1:0] chan;
  } sel_t;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_SEL  = 2'd1,
    A_FLAG = 2'd2
  } addr_e;

  typedef enum logic [1:0] {
    SLP_IDLE  = 2'd0,
    SLP_QUIET = 2'd1,
    SLP_DEEP  = 2'd2,
    SLP_STBY  = 2'd3
  } sleep_e;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int SHORT_CYC = 13,
  parameter int LONG_CYC  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic long_i,
  output logic busy_o,
  output logic sample_o,
  output logic held_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx = long_i ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
    sample_o = busy_q && tick_i && (cnt_q == '0);
    held_o   = busy_q && (cnt_q != '0);
    done_o   = busy_q && tick_i && (cnt_q == last_idx) && !abort_i;
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (abort_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q && tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  // R2 R3: the count never runs past the longest conversion
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CNT_W'(LONG_CYC - 1)));

  // R2: a completion without restart leaves the timer idle
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/adc_sel_buf.sv
module adc_sel_buf
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  sel_t              wr_sel_i,
  input  logic              win_i,
  input  logic              latch_i,
  output logic [CHAN_W-1:0] pend_chan_o,
  output sel_t              conv_o,
  output logic              conv_ref_new_o
);
  sel_t pend_q, pend_d;
  sel_t act_q, act_d;
  sel_t conv_q, conv_d;
  logic dirty_q, dirty_d;
  logic cdirty_q, cdirty_d;
  logic ref_chg;

  always_comb begin
    pend_d   = wr_i ? wr_sel_i : pend_q;
    act_d    = win_i ? pend_q : act_q;
    ref_chg  = (act_d.refsel != act_q.refsel);
    dirty_d  = ref_chg ? 1'b1 : (latch_i ? 1'b0 : dirty_q);
    conv_d   = latch_i ? act_q : conv_q;
    cdirty_d = latch_i ? dirty_q : cdirty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      act_q    <= '0;
      conv_q   <= '0;
      dirty_q  <= 1'b0;
      cdirty_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      act_q    <= act_d;
      conv_q   <= conv_d;
      dirty_q  <= dirty_d;
      cdirty_q <= cdirty_d;
    end
  end

  assign pend_chan_o    = pend_q.chan;
  assign conv_o         = conv_q;
  assign conv_ref_new_o = cdirty_q;

  // R7: a sampled conversion inherits the pending reference-change mark
  p_ref_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_i && dirty_q) |=> conv_ref_new_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int SHORT_CYC = 13,
  parameter int LONG_CYC  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              cpu_halt_i,
  input  logic [1:0]        sleep_kind_i,
  input  logic [RES_W-1:0]  core_code_i,
  output logic              core_sample_o,
  output logic [CHAN_W-1:0] core_chan_o,
  output logic [REF_W-1:0]  core_ref_o,
  output logic              busy_o,
  output logic              irq_flag_o,
  output logic              irq_o,
  output logic [RES_W-1:0]  result_o,
  output logic              stale_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic en_q, en_d, free_q, free_d, ie_q, ie_d;
  logic first_q, first_d, flag_q, flag_d, halt_q;
  logic stale_q, stale_d;
  logic [RES_W-1:0] result_q, result_d;

  logic wr_ctrl, wr_sel, wr_flag;
  logic busy, held, done, sample;
  logic free_run, quiet_kind, halt_rise;
  logic sw_start, nap_start, conv_start, win;
  logic [CHAN_W-1:0] pend_chan;
  sel_t conv_sel;
  logic conv_ref_new;
  sleep_e kind;

  always_comb begin
    kind       = sleep_e'(sleep_kind_i);
    wr_ctrl    = wr_en_i && (addr_e'(wr_addr_i) == A_CTRL);
    wr_sel     = wr_en_i && (addr_e'(wr_addr_i) == A_SEL);
    wr_flag    = wr_en_i && (addr_e'(wr_addr_i) == A_FLAG);
    free_run   = en_q && free_q;
    quiet_kind = (kind == SLP_IDLE) || (kind == SLP_QUIET);
    halt_rise  = cpu_halt_i && !halt_q;
    sw_start   = start_i && en_q && !busy;
    nap_start  = halt_rise && quiet_kind && en_q && !busy && !free_q && ie_q;
    conv_start = sw_start || nap_start || (done && free_run);
    win        = !free_run || held || (!busy && flag_q);
  end

  always_comb begin
    en_d     = wr_ctrl ? wr_data_i[0] : en_q;
    free_d   = wr_ctrl ? wr_data_i[1] : free_q;
    ie_d     = wr_ctrl ? wr_data_i[2] : ie_q;
    if (wr_ctrl && wr_data_i[0] && !en_q) first_d = 1'b1;
    else if (done)                         first_d = 1'b0;
    else                                   first_d = first_q;
    if (done)                         flag_d = 1'b1;
    else if (wr_flag && wr_data_i[0]) flag_d = 1'b0;
    else                              flag_d = flag_q;
    result_d = done ? core_code_i : result_q;
    stale_d  = done ? (conv_ref_new || (free_run && (conv_sel.chan != pend_chan)))
                    : stale_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q     <= 1'b0;
      free_q   <= 1'b0;
      ie_q     <= 1'b0;
      first_q  <= 1'b0;
      flag_q   <= 1'b0;
      halt_q   <= 1'b0;
      stale_q  <= 1'b0;
      result_q <= '0;
    end else begin
      en_q     <= en_d;
      free_q   <= free_d;
      ie_q     <= ie_d;
      first_q  <= first_d;
      flag_q   <= flag_d;
      halt_q   <= cpu_halt_i;
      stale_q  <= stale_d;
      result_q <= result_d;
    end
  end

  adc_conv_timer #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (adc_tick_i),
    .start_i  (conv_start),
    .abort_i  (!en_q),
    .long_i   (first_q),
    .busy_o   (busy),
    .sample_o (sample),
    .held_o   (held),
    .done_o   (done)
  );

  adc_sel_buf i_selbuf (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .wr_i           (wr_sel),
    .wr_sel_i       (sel_t'(wr_data_i)),
    .win_i          (win),
    .latch_i        (sample),
    .pend_chan_o    (pend_chan),
    .conv_o         (conv_sel),
    .conv_ref_new_o (conv_ref_new)
  );

  assign core_sample_o = sample;
  assign core_chan_o   = conv_sel.chan;
  assign core_ref_o    = conv_sel.refsel;
  assign busy_o        = busy;
  assign irq_flag_o    = flag_q;
  assign irq_o         = flag_q && ie_q;
  assign result_o      = result_q;
  assign stale_o       = stale_q;

  // R2: an accepted software start makes the timer busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && en_q && !busy_o) |=> busy_o);

  // R8: every completion leaves the flag set
  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> irq_flag_o);

  // R11: a disabled sequencer is idle one clock later
  p_off_idle_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_q |=> !busy_o);

  // R5: the core samples only inside a conversion
  p_sample_busy_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_sample_o |-> busy_o);

  // R5: between samples the selection shown to the core does not move
  p_core_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !core_sample_o |=> $stable(core_chan_o) && $stable(core_ref_o));

  // R10: a qualifying halt into a quiet sleep state starts a conversion
  p_nap_start_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_halt_i && !halt_q && quiet_kind && en_q && !busy_o && !free_q && ie_q)
      |=> busy_o);
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [5:0] wr_data;
  logic       start;
  logic       halt;
  logic [1:0] kind;
  logic [9:0] core_code;
  logic       core_sample, busy, flag, irq, stale;
  logic [3:0] core_chan;
  logic [1:0] core_ref;
  logic [9:0] result;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  assign core_code = {core_ref, core_chan, 4'h9};

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .adc_tick_i    (tick),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .start_i       (start),
    .cpu_halt_i    (halt),
    .sleep_kind_i  (kind),
    .core_code_i   (core_code),
    .core_sample_o (core_sample),
    .core_chan_o   (core_chan),
    .core_ref_o    (core_ref),
    .busy_o        (busy),
    .irq_flag_o    (flag),
    .irq_o         (irq),
    .result_o      (result),
    .stale_o       (stale)
  );

  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  function automatic logic [9:0] code(input logic [3:0] ch, input logic [1:0] rf);
    return {rf, ch, 4'h9};
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    int g;
    n = 0; g = 0;
    while (busy && g < 5000) begin
      if (tick) n++;
      step();
      g++;
    end
  endtask

  task automatic wait_ticks(input int k);
    int n, g;
    n = 0; g = 0;
    while (n < k && g < 5000) begin
      if (tick) n++;
      step();
      g++;
    end
  endtask

  task automatic wait_flag();
    int g;
    g = 0;
    while (!flag && g < 5000) begin
      step();
      g++;
    end
    chk("R6 flag reached", flag, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1 busy in reset", busy, 0);
    chk("R1 flag in reset", flag, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 busy", busy, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 stale", stale, 0);
    chk("R1 result", result, 0);
  endtask

  task automatic t_disabled();
    wr(2'd1, 6'h00);
    pulse_start();
    repeat (4) step();
    chk("R4 busy while disabled", busy, 0);
    chk("R4 flag while disabled", flag, 0);
  endtask

  task automatic t_first_long();
    int n;
    wr(2'd0, 6'h05);
    step();
    pulse_start();
    chk("R2 busy after start", busy, 1);
    wait_idle(n);
    chk("R3 first conversion ticks", n, 25);
    chk("R2 result after first", result, code(4'd0, 2'd0));
    chk("R2 flag after first", flag, 1);
    chk("R9 irq with enable", irq, 1);
  endtask

  task automatic t_flag_clear();
    wr(2'd2, 6'h00);
    step();
    chk("R8 flag kept on zero write", flag, 1);
    wr(2'd2, 6'h01);
    step();
    chk("R8 flag cleared", flag, 0);
    chk("R9 irq follows flag", irq, 0);
  endtask

  task automatic t_single();
    int n;
    pulse_start();
    wait_idle(n);
    chk("R2 single conversion ticks", n, 13);
    chk("R2 flag set", flag, 1);
    repeat (30) step();
    chk("R2 stays idle in single mode", busy, 0);
    wr(2'd0, 6'h01);
    step();
    chk("R9 irq masked", irq, 0);
    wr(2'd0, 6'h05);
    wr(2'd2, 6'h01);
  endtask

  task automatic t_window();
    int n;
    wr(2'd1, 6'h03);
    step();
    pulse_start();
    wait_ticks(2);
    wr(2'd1, 6'h04);
    wait_idle(n);
    chk("R5 late write not used", result, code(4'd3, 2'd0));
    chk("R5 stale clear", stale, 0);
    step();
    pulse_start();
    wait_idle(n);
    chk("R5 late write used next", result, code(4'd4, 2'd0));
    wr(2'd2, 6'h01);
  endtask

  task automatic t_ref_change();
    int n;
    wr(2'd1, 6'h25);
    step();
    pulse_start();
    wait_idle(n);
    chk("R7 result after ref change", result, code(4'd5, 2'd2));
    chk("R7 first after ref change stale", stale, 1);
    step();
    pulse_start();
    wait_idle(n);
    chk("R7 second after ref change clean", stale, 0);
    wr(2'd2, 6'h01);
  endtask

  task automatic t_sleep();
    int n;
    kind = 2'd2;
    halt = 1'b1;
    repeat (6) step();
    chk("R10 deep sleep starts nothing", busy, 0);
    halt = 1'b0;
    repeat (2) step();
    kind = 2'd1;
    halt = 1'b1;
    step();
    step();
    chk("R10 quiet sleep starts conversion", busy, 1);
    halt = 1'b0;
    wait_idle(n);
    chk("R10 conversion completes after wake", flag, 1);
    chk("R10 result", result, code(4'd5, 2'd2));
    wr(2'd2, 6'h01);
  endtask

  task automatic t_free_run();
    wr(2'd1, 6'h21);
    wr(2'd0, 6'h07);
    step();
    pulse_start();
    wait_flag();
    chk("R6 first free result", result, code(4'd1, 2'd2));
    chk("R6 first free stale", stale, 0);
    chk("R6 restarted automatically", busy, 1);
    wr(2'd2, 6'h01);
    wait_ticks(2);
    wr(2'd1, 6'h22);
    wait_flag();
    chk("R6 old channel after change", result, code(4'd1, 2'd2));
    chk("R6 old-channel result stale", stale, 1);
    wr(2'd2, 6'h01);
    wait_flag();
    chk("R6 new channel next", result, code(4'd2, 2'd2));
    chk("R6 new-channel result clean", stale, 0);
  endtask

  task automatic t_abort();
    wait_ticks(3);
    chk("R11 busy before disable", busy, 1);
    wr(2'd0, 6'h00);
    step();
    chk("R11 disable aborts", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 6'h00;
    start = 1'b0; halt = 1'b0; kind = 2'd0;
    t_reset();
    t_disabled();
    t_first_long();
    t_flag_clear();
    t_single();
    t_window();
    t_ref_change();
    t_sleep();
    t_free_run();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: R2 run did not finish, got hang expected end");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule